// File: doc/BRIEF.md
# Receive TCP/UDP Checksum Verifier

This block watches a received Ethernet frame one byte per accepted cycle and judges its transport checksum. It finds IPv4 or IPv6 by the EtherType, reads the IP version, header length, lengths, fragment controls and protocol, then sums the transport segment and its pseudo-header. The sum uses 16-bit ones'-complement arithmetic. The pseudo-header is the two IP addresses, the protocol number and the transport length.

At the end of each frame the block returns one 32-bit status word with a one-cycle strobe. The raw sum sits in the low half. Five flags above it give the IP version, TCP or UDP, fragment and checksum error. A receive path attaches this word to the frame's descriptor. Frames carry no VLAN tag. IPv4 options are skipped through the header-length field. IPv6 extension headers are not parsed.

Top module: `l4_csum_check`

## Requirements
- R1: status_o[15:0] is the ones'-complement sum, with end-around carry, of the IP source and destination addresses, the protocol number, the transport length and every transport byte. Bytes at even offsets from the transport start are the high bytes of a 16-bit word. A non-fragmented frame whose checksum is correct reports 0xFFFF.
- R2: status_o[16] is set for a supported, non-fragmented frame whose sum is not 0xFFFF.
- R3: status_o[17] is set for an IPv4 frame when bit 13 (more fragments) of header bytes 6-7 is set or bits 12:0 (offset) are non-zero. A fragment never sets status_o[16]. The don't-fragment bit 14 alone is not a fragment.
- R4: status_o[18] is set for protocol 6 (TCP) and clear for protocol 17 (UDP).
- R5: status_o[20] marks IPv4: EtherType 0x0800, version 4, IHL at least 5, transport start at byte 14+4*IHL. status_o[19] marks IPv6: EtherType 0x86DD, version 6, transport start at byte 54. The two are never set together.
- R6: A transport segment of odd length is summed as if padded with one zero byte. Bytes after the length given by the IP header are ignored.
- R7: An IPv4 UDP frame whose checksum field (transport bytes 6-7) is zero reports no error. An IPv6 UDP frame gets no such exemption.
- R8: A frame that is not IPv4/IPv6, or that carries a protocol other than TCP or UDP, reports a status word of all zeros.
- R9: status_vld_o is high for exactly one cycle, the cycle after the byte carrying eof_i is accepted. status_o changes only with that strobe. Cycles with valid_i low are ignored, whatever sof_i, eof_i and data_i hold.
- R10: During and after reset, status_vld_o is low and status_o is zero.
- R11: A byte with sof_i restarts parsing and summing, so a frame can start in the cycle right after the previous frame's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | data_i holds a frame byte this cycle |
| sof_i | input | 1 | First byte of a frame |
| eof_i | input | 1 | Last byte of a frame |
| data_i | input | 8 | Frame byte |
| status_o | output | 32 | Sum in 15:0, flags in 20:16 |
| status_vld_o | output | 1 | One-cycle strobe for status_o |

## Verification
Two events can land on the same byte. When a UDP segment holds only its 8-byte header, the last byte of the frame is also the low byte of the checksum field. That byte must be captured for the zero-checksum exemption in the same cycle that the final judgement is made. The bench sends that frame with a zero checksum and expects no error flag. A second coincidence is a new frame's start-of-frame byte arriving in the cycle right after an end-of-frame byte. Two frames are sent back to back, and each must produce its own status word unchanged by the other.

// File: rtl/l4cc_pkg.sv
package l4cc_pkg;
  localparam logic [15:0] ETYPE_V4  = 16'h0800;
  localparam logic [15:0] ETYPE_V6  = 16'h86DD;
  localparam logic [7:0]  PROTO_TCP = 8'd6;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam int ETH_LEN = 14;
  localparam int V6_LEN  = 40;
  localparam int V4_ADR_LO = ETH_LEN + 12;
  localparam int V4_ADR_HI = ETH_LEN + 19;
  localparam int V6_ADR_LO = ETH_LEN + 8;
  localparam int V6_ADR_HI = ETH_LEN + 39;
  localparam int ST_ERR  = 16;
  localparam int ST_FRAG = 17;
  localparam int ST_TCP  = 18;
  localparam int ST_V6   = 19;
  localparam int ST_V4   = 20;

  // raw header bytes captured by absolute frame offset
  typedef struct packed {
    logic [15:0] etype;   // 12-13
    logic [7:0]  vihl;    // 14
    logic [15:0] w16;     // 16-17
    logic [15:0] w18;     // 18-19
    logic [15:0] w20;     // 20-21
    logic [7:0]  b23;     // 23
    logic [15:0] l4ck;    // transport checksum field
  } hdr_t;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic is_v4(input hdr_t h);
    return h.etype == ETYPE_V4 && h.vihl[7:4] == 4'd4 && h.vihl[3:0] >= 4'd5;
  endfunction

  function automatic logic is_v6(input hdr_t h);
    return h.etype == ETYPE_V6 && h.vihl[7:4] == 4'd6;
  endfunction

  function automatic logic [16:0] l4_lo(input hdr_t h);
    return is_v4(h) ? 17'(ETH_LEN) + 17'({h.vihl[3:0], 2'b00}) : 17'(ETH_LEN + V6_LEN);
  endfunction

  function automatic logic [16:0] l4_hi(input hdr_t h);
    return is_v4(h) ? 17'(ETH_LEN) + {1'b0, h.w16} : 17'(ETH_LEN + V6_LEN) + {1'b0, h.w18};
  endfunction

  function automatic logic [15:0] l4_len(input hdr_t h);
    return is_v4(h) ? h.w16 - {10'd0, h.vihl[3:0], 2'b00} : h.w18;
  endfunction

  function automatic logic [7:0] proto_of(input hdr_t h);
    return is_v4(h) ? h.b23 : h.w20[15:8];
  endfunction

  function automatic logic frag_of(input hdr_t h);
    return is_v4(h) && (h.w20[13] || h.w20[12:0] != 13'd0);
  endfunction
endpackage

// File: rtl/l4cc_parser.sv
module l4cc_parser
  import l4cc_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic [7:0] data_i,
  output hdr_t       hdr_d_o,
  output logic       in_sum_o,
  output logic       odd_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q, idx;
  hdr_t             hdr_q, base, hdr_d;
  logic             v4, v6, in_adr, in_l4;
  logic [16:0]      idx_x, lo, hi;

  always_comb begin
    idx   = sof_i ? '0 : idx_q;
    base  = sof_i ? '0 : hdr_q;
    idx_x = 17'(idx);
    v4    = is_v4(base);
    v6    = is_v6(base);
    lo    = l4_lo(base);
    hi    = l4_hi(base);
    hdr_d = base;
    case (idx)
      IDX_W'(12): hdr_d.etype[15:8] = data_i;
      IDX_W'(13): hdr_d.etype[7:0]  = data_i;
      IDX_W'(14): hdr_d.vihl        = data_i;
      IDX_W'(16): hdr_d.w16[15:8]   = data_i;
      IDX_W'(17): hdr_d.w16[7:0]    = data_i;
      IDX_W'(18): hdr_d.w18[15:8]   = data_i;
      IDX_W'(19): hdr_d.w18[7:0]    = data_i;
      IDX_W'(20): hdr_d.w20[15:8]   = data_i;
      IDX_W'(21): hdr_d.w20[7:0]    = data_i;
      IDX_W'(23): hdr_d.b23         = data_i;
      default: ;
    endcase
    if ((v4 || v6) && idx_x == lo + 17'd6) hdr_d.l4ck[15:8] = data_i;
    if ((v4 || v6) && idx_x == lo + 17'd7) hdr_d.l4ck[7:0]  = data_i;
    in_adr = (v4 && idx_x >= 17'(V4_ADR_LO) && idx_x <= 17'(V4_ADR_HI)) ||
             (v6 && idx_x >= 17'(V6_ADR_LO) && idx_x <= 17'(V6_ADR_HI));
    in_l4  = (v4 || v6) && idx_x >= lo && idx_x < hi;
  end

  assign hdr_d_o  = hdr_d;
  assign in_sum_o = valid_i && (in_adr || in_l4);
  assign odd_o    = idx[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      hdr_q <= '0;
    end else if (valid_i) begin
      idx_q <= (idx == IDX_MAX) ? idx : idx + 1'b1;
      hdr_q <= hdr_d;
    end
  end
endmodule

// File: rtl/l4cc_accum.sv
module l4cc_accum
  import l4cc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        sof_i,
  input  logic        in_sum_i,
  input  logic        odd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] sum_d_o
);
  logic [15:0] acc_q, base, term;

  always_comb begin
    base    = sof_i ? 16'd0 : acc_q;
    term    = odd_i ? {8'd0, data_i} : {data_i, 8'd0};
    sum_d_o = in_sum_i ? oc_add(base, term) : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= sum_d_o;
  end
endmodule

// File: rtl/l4cc_status.sv
module l4cc_status
  import l4cc_pkg::*;
#(
  parameter int ST_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            eof_i,
  input  logic [15:0]     sum_d_i,
  input  hdr_t            hdr_d_i,
  output logic [ST_W-1:0] status_o,
  output logic            status_vld_o
);
  logic [15:0]     fin;
  logic [7:0]      proto;
  logic            v4, v6, tcp, udp, frag, zero_ok, err;
  logic [ST_W-1:0] word;

  always_comb begin
    v4      = is_v4(hdr_d_i);
    v6      = is_v6(hdr_d_i);
    proto   = proto_of(hdr_d_i);
    frag    = frag_of(hdr_d_i);
    tcp     = proto == PROTO_TCP;
    udp     = proto == PROTO_UDP;
    fin     = oc_add(oc_add(sum_d_i, {8'd0, proto}), l4_len(hdr_d_i));
    zero_ok = v4 && udp && hdr_d_i.l4ck == 16'd0;
    err     = !frag && fin != 16'hFFFF && !zero_ok;
    word    = '0;
    if ((v4 || v6) && (tcp || udp)) begin
      word[15:0]    = fin;
      word[ST_ERR]  = err;
      word[ST_FRAG] = frag;
      word[ST_TCP]  = tcp;
      word[ST_V6]   = v6;
      word[ST_V4]   = v4;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o     <= '0;
      status_vld_o <= 1'b0;
    end else begin
      status_vld_o <= valid_i && eof_i;
      if (valid_i && eof_i) status_o <= word;
    end
  end
endmodule

// File: rtl/l4_csum_check.sv
module l4_csum_check
  import l4cc_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int ST_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            sof_i,
  input  logic            eof_i,
  input  logic [7:0]      data_i,
  output logic [ST_W-1:0] status_o,
  output logic            status_vld_o
);
  hdr_t        hdr_d;
  logic        in_sum, odd;
  logic [15:0] sum_d;

  l4cc_parser #(.IDX_W(IDX_W)) u_parse (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .data_i(data_i), .hdr_d_o(hdr_d), .in_sum_o(in_sum), .odd_o(odd)
  );

  l4cc_accum u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .in_sum_i(in_sum), .odd_i(odd), .data_i(data_i), .sum_d_o(sum_d)
  );

  l4cc_status #(.ST_W(ST_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .eof_i(eof_i),
    .sum_d_i(sum_d), .hdr_d_i(hdr_d), .status_o(status_o),
    .status_vld_o(status_vld_o)
  );
endmodule

// File: rtl/l4_csum_check_sva.sv
module l4_csum_check_sva #(
  parameter int ST_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            eof_i,
  input logic [ST_W-1:0] status_o,
  input logic            status_vld_o
);
  // R9
  vld_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && eof_i |=> status_vld_o);
  // R9
  vld_only_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> $past(valid_i && eof_i));
  // R9
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_vld_o |-> $stable(status_o));
  // R5
  one_version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[20:19]));
  // R3
  frag_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[17] |-> !status_o[16]);
  // R4
  tcp_needs_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[18] |-> (status_o[20] || status_o[19]));
  // R8
  unsup_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o && !status_o[20] && !status_o[19] |-> status_o == '0);
endmodule

bind l4_csum_check l4_csum_check_sva #(.ST_W(ST_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .eof_i(eof_i),
  .status_o(status_o), .status_vld_o(status_vld_o)
);

// File: tb/l4_csum_check_test.sv
module l4_csum_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0]  data = 8'd0;
  logic [31:0] status;
  logic        status_vld;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  fr [0:511];
  logic [31:0] cap [0:63];
  int cap_n = 0;

  always #10 clk = ~clk;

  l4_csum_check uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .status_o(status), .status_vld_o(status_vld)
  );

  always @(negedge clk) if (rst_n && status_vld) begin
    cap[cap_n % 64] = status;
    cap_n++;
  end

  // kind: 0 IPv4, 1 IPv6, 2 non-IP; expf = {v4,v6,tcp,frag,err}
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  proto;
    logic [7:0]  len;
    logic [3:0]  ihl;
    logic [15:0] fragw;
    logic        bad;
    logic        ckz;
    logic [3:0]  pad;
    logic [4:0]  expf;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0, 8'd6,  8'd20, 4'd5, 16'h4000, 1'b0, 1'b0, 4'd0, 5'b10100},
    '{2'd0, 8'd17, 8'd13, 4'd5, 16'h0000, 1'b0, 1'b0, 4'd0, 5'b10000},
    '{2'd0, 8'd6,  8'd24, 4'd6, 16'h0000, 1'b0, 1'b0, 4'd0, 5'b10100},
    '{2'd1, 8'd17, 8'd15, 4'd0, 16'h0000, 1'b0, 1'b0, 4'd0, 5'b01000},
    '{2'd1, 8'd6,  8'd20, 4'd0, 16'h0000, 1'b1, 1'b0, 4'd0, 5'b01101},
    '{2'd0, 8'd17, 8'd12, 4'd5, 16'h0000, 1'b1, 1'b0, 4'd0, 5'b10001},
    '{2'd0, 8'd17, 8'd11, 4'd5, 16'h0000, 1'b0, 1'b1, 4'd0, 5'b10000},
    '{2'd0, 8'd6,  8'd20, 4'd5, 16'h2000, 1'b1, 1'b0, 4'd0, 5'b10110},
    '{2'd0, 8'd17, 8'd10, 4'd5, 16'h0010, 1'b0, 1'b0, 4'd0, 5'b10010},
    '{2'd0, 8'd1,  8'd12, 4'd5, 16'h0000, 1'b0, 1'b0, 4'd0, 5'b00000},
    '{2'd2, 8'd17, 8'd12, 4'd5, 16'h0000, 1'b0, 1'b0, 4'd0, 5'b00000},
    '{2'd0, 8'd17, 8'd9,  4'd5, 16'h0000, 1'b0, 1'b0, 4'd4, 5'b10000},
    '{2'd1, 8'd17, 8'd14, 4'd0, 16'h0000, 1'b0, 1'b1, 4'd0, 5'b01001},
    '{2'd1, 8'd6,  8'd21, 4'd0, 16'h0000, 1'b0, 1'b0, 4'd3, 5'b01100}
  };

  function automatic logic [15:0] ocs(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] sum_rng(input int s, input int len);
    logic [15:0] acc = 16'd0;
    for (int k = 0; k < len; k++)
      acc = ocs(acc, k[0] ? {8'd0, fr[s+k]} : {fr[s+k], 8'd0});
    return acc;
  endfunction

  function automatic logic [15:0] model(input int b, input int kind, input int l4s,
                                        input int len, input logic [7:0] proto);
    logic [15:0] acc;
    acc = (kind == 0) ? sum_rng(b + 26, 8) : sum_rng(b + 22, 32);
    acc = ocs(acc, sum_rng(l4s, len));
    acc = ocs(acc, {8'd0, proto});
    return ocs(acc, 16'(len));
  endfunction

  task automatic build(input int b, input vec_t v, output int n, output logic [31:0] exp);
    int p, l4s, ckp, hl, len;
    logic [15:0] s;
    p = b; len = int'(v.len);
    for (int k = 0; k < 6; k++) fr[p+k] = 8'(8'h02 + k);
    for (int k = 6; k < 12; k++) fr[p+k] = 8'(8'h50 + k);
    {fr[p+12], fr[p+13]} = (v.kind == 0) ? 16'h0800 : (v.kind == 1) ? 16'h86DD : 16'h0806;
    p += 14;
    if (v.kind == 2) begin
      for (int k = 0; k < 28; k++) fr[p+k] = 8'(k * 3);
      n = p + 28 - b; exp = 32'd0;
      return;
    end
    if (v.kind == 0) begin
      hl = int'(v.ihl) * 4;
      fr[p] = {4'd4, v.ihl}; fr[p+1] = 8'd0;
      {fr[p+2], fr[p+3]} = 16'(hl + len);
      fr[p+4] = 8'h12; fr[p+5] = 8'h34;
      {fr[p+6], fr[p+7]} = v.fragw;
      fr[p+8] = 8'd64; fr[p+9] = v.proto; fr[p+10] = 8'd0; fr[p+11] = 8'd0;
      for (int k = 0; k < 8; k++) fr[p+12+k] = 8'(8'hC0 + k * 7);
      for (int k = 20; k < hl; k++) fr[p+k] = 8'h01;
      p += hl;
    end else begin
      fr[p] = 8'h60; fr[p+1] = 8'd0; fr[p+2] = 8'd0; fr[p+3] = 8'd0;
      {fr[p+4], fr[p+5]} = 16'(len);
      fr[p+6] = v.proto; fr[p+7] = 8'd64;
      for (int k = 0; k < 32; k++) fr[p+8+k] = 8'(8'h20 + k * 5);
      p += 40;
    end
    l4s = p;
    for (int k = 0; k < len; k++) fr[l4s+k] = 8'(k * 37 + len * 11 + 5);
    ckp = l4s + ((v.proto == 8'd6) ? 16 : 6);
    if (v.proto == 8'd6 || v.proto == 8'd17) begin
      fr[ckp] = 8'd0; fr[ckp+1] = 8'd0;
    end
    s = model(b, int'(v.kind), l4s, len, v.proto);
    if (!v.ckz && (v.proto == 8'd6 || v.proto == 8'd17)) {fr[ckp], fr[ckp+1]} = ~s;
    if (v.bad) fr[l4s+len-1] = fr[l4s+len-1] ^ 8'h5A;
    s = model(b, int'(v.kind), l4s, len, v.proto);
    p += len;
    for (int k = 0; k < int'(v.pad); k++) fr[p+k] = 8'hEE;
    p += int'(v.pad);
    n = p - b;
    exp = (v.expf == 5'd0) ? 32'd0 : {11'd0, v.expf, s};
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic send_seg(input int s, input int n, input bit gap);
    for (int k = 0; k < n; k++) begin
      if (gap && (k % 5) == 2) begin
        @(negedge clk); valid = 1'b0; sof = 1'b1; eof = 1'b1; data = 8'hFF;
      end
      @(negedge clk); valid = 1'b1; sof = (k == 0); eof = (k == n - 1); data = fr[s+k];
    end
  endtask

  task automatic settle();
    repeat (3) begin
      @(negedge clk); valid = 1'b0; sof = 1'b0; eof = 1'b0; data = 8'd0;
    end
    #1;
  endtask

  task automatic run_vec(input vec_t v);
    int n, prev;
    logic [31:0] exp, got;
    build(0, v, n, exp);
    prev = cap_n;
    send_seg(0, n, 1'b0);
    settle();
    chk("R9 one strobe per frame", 32'(cap_n - prev), 32'd1);
    got = cap[(cap_n - 1) % 64];
    if (v.expf == 5'd0) chk("R8 unsupported word", got, 32'd0);
    else begin
      chk("R1 sum", {16'd0, got[15:0]}, {16'd0, exp[15:0]});
      chk("R2 error flag", {31'd0, got[16]}, {31'd0, v.expf[0]});
      chk("R3 fragment flag", {31'd0, got[17]}, {31'd0, v.expf[1]});
      chk("R4 tcp flag", {31'd0, got[18]}, {31'd0, v.expf[2]});
      chk("R5 version flags", {30'd0, got[20:19]}, {30'd0, v.expf[4:3]});
      if (!v.bad && !v.ckz && !v.expf[1])
        chk("R1 correct gives FFFF", {16'd0, got[15:0]}, 32'h0000FFFF);
    end
    if (v.pad != 4'd0 || v.len[0]) chk("R6 odd/pad word", got, exp);
    if (v.ckz) chk("R7 zero checksum", {31'd0, got[16]}, {31'd0, v.expf[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int na, nb, prev;
    logic [31:0] ea, eb;
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R10 reset status", status, 32'd0);
    chk("R10 reset strobe", {31'd0, status_vld}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 after reset", {status_vld, status[30:0]}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7: frame ends on the low checksum byte, zero checksum
    v = '{2'd0, 8'd17, 8'd8, 4'd5, 16'h0000, 1'b0, 1'b1, 4'd0, 5'b10000};
    build(0, v, na, ea);
    prev = cap_n;
    send_seg(0, na, 1'b0);
    settle();
    chk("R7 checksum on last byte", cap[(cap_n - 1) % 64], ea);

    // R9: idle cycles with junk controls inside a frame
    build(0, VEC[1], na, ea);
    prev = cap_n;
    send_seg(0, na, 1'b1);
    settle();
    chk("R9 gaps count", 32'(cap_n - prev), 32'd1);
    chk("R9 gaps ignored", cap[(cap_n - 1) % 64], ea);

    // R11: back-to-back frames
    build(0, VEC[3], na, ea);
    build(na, VEC[5], nb, eb);
    prev = cap_n;
    send_seg(0, na, 1'b0);
    send_seg(na, nb, 1'b0);
    settle();
    chk("R11 two strobes", 32'(cap_n - prev), 32'd2);
    chk("R11 first frame", cap[prev % 64], ea);
    chk("R11 second frame", cap[(prev + 1) % 64], eb);
    chk("R9 status held", status, eb);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule